// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This block is a byte-oriented master for a single-wire, open-drain bus. A host writes bytes into a one-deep transmit buffer through a data port. The engine moves each byte into a shift register and sends it as eight timed bit slots, least significant bit first. In every slot it samples the line, so the sampled byte shows up in a receive buffer. To read a byte from a slave, the host sends the all-ones byte 8'hFF. A slave answers a 0 by holding the line low through the sample point, and the receive buffer then holds the slave's byte. The host repeats this for every byte it wants to read.

The engine also issues bus reset pulses and records whether a slave answered with a presence pulse. It flags a slave that holds the line low for longer than a timeout. The host can take direct control of the line. A soft reset aborts any transfer and keeps the host-visible settings and the receive data. A mode bit selects standard or overdrive timing. All bus timing is counted in ticks of an external 1 us enable pulse, and nothing on the bus moves while no tick arrives.

Control register bits: [0] start bus reset (reads 1 while the reset is pending), [1] drive-low value in direct mode, [2] soft reset, [3] overdrive, [4] direct-drive enable, [7] synchronized line level (read-only). Status bits: [0] presence flag, [1] presence result, [2] transmit buffer empty, [3] shift register empty, [4] receive full, [5] slave-low flag, [6] not busy, [7] synchronized line level.

Top module: `owm_engine`

## Requirements
- R1: Writing control bit 0 as 1 starts a bus reset. The line is held low for 480 ticks (overdrive: 60). Presence is sampled 70 ticks after the line is released (overdrive: 9). The sampled level is latched into status bit 1, where 0 means a slave answered. At the end of the reset, status bit 0 sets. A status read clears status bit 0 and leaves bit 1 unchanged.
- R2: Sending 8'hFF while a slave pulls low during some slots places that slave's byte, LSB first, in the receive buffer (data_rdata). This works for every byte sent this way. In general the receive byte is the wire-AND of the sent byte and the slave's byte.
- R3: Status bit 2 (transmit buffer empty) reads 0 in the cycle after a data write. It returns to 1 when the byte moves into the shift register. A second byte can wait in the buffer while the first one shifts.
- R4: Status bit 3 (shift register empty) clears when a byte is loaded and sets again after its eighth slot. Bits go out LSB first. In standard mode a 1 drives the line low for 6 ticks, a 0 for 60 ticks, and a slot lasts 70 ticks. In overdrive these are 1, 8 and 10 ticks.
- R5: Status bit 4 (receive full) sets when a byte completes and clears after a data_re pulse. If a completion falls in the same cycle as the read, the flag stays set.
- R6: Status bit 5 sets when the line stays low without master drive for more than SINT_TICKS ticks (960). It does not set for a 900-tick low. A status read clears it.
- R7: With control bit 4 set, dq_oe follows control bit 1, and a 1 pulls the line low. Control read bit 7 and status bit 7 both show the synchronized line level. A written bit 7 has no effect.
- R8: Setting control bit 2 aborts any transfer, releases the line and empties the transmit buffer and shift register. The receive byte, receive full flag and mode bits keep their values.
- R9: Status bit 6 reads 0 while a byte transfer or reset is pending or running, or while the line is low. Otherwise it reads 1.
- R10: While no tick pulse arrives, the line is not driven and a written byte stays in the transmit buffer. It is sent once ticks resume.
- R11: After reset, status reads 8'hCE, control read is 8'h80 and data_rdata is 8'h00 (with the line idle high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 1 us timing enable pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register read value |
| data_we | input | 1 | Transmit buffer write strobe |
| data_wdata | input | 8 | Byte to send |
| data_re | input | 1 | Receive buffer read strobe |
| data_rdata | output | 8 | Receive buffer value |
| status_re | input | 1 | Status read strobe, clears presence and slave-low flags |
| status | output | 8 | Status flags |
| dq_oe | output | 1 | Open-drain enable, 1 pulls the line low |
| dq_in | input | 1 | Line level, asynchronous |

## Verification
Two functions can fall in the same cycle. A host write to the data port can land while the previous byte is shifting. The buffer-to-shift transfer can also fall on the same tick as a new write. The bench provokes this by queueing a second byte as soon as the buffer reports empty. It judges the result by the order of the bytes that a bench slave model decodes from the line, and by the buffer flags while both bytes are in flight. It also checks the soft reset landing in the middle of a slot, and the receive flags that must survive it.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int CNT_W  = 10;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  // control register bit positions
  localparam int CTL_RST    = 0;
  localparam int CTL_FORCE  = 1;
  localparam int CTL_SOFT   = 2;
  localparam int CTL_FAST   = 3;
  localparam int CTL_DIRECT = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RESET, SQ_SLOT} sq_state_e;

  // all values in ticks, counted from the start of the phase
  function automatic logic [CNT_W-1:0] low_one(input logic fast);
    return fast ? CNT_W'(1) : CNT_W'(6);
  endfunction
  function automatic logic [CNT_W-1:0] low_zero(input logic fast);
    return fast ? CNT_W'(8) : CNT_W'(60);
  endfunction
  function automatic logic [CNT_W-1:0] sample_at(input logic fast);
    return fast ? CNT_W'(2) : CNT_W'(15);
  endfunction
  function automatic logic [CNT_W-1:0] slot_last(input logic fast);
    return fast ? CNT_W'(9) : CNT_W'(69);
  endfunction
  function automatic logic [CNT_W-1:0] reset_low(input logic fast);
    return fast ? CNT_W'(60) : CNT_W'(480);
  endfunction
  function automatic logic [CNT_W-1:0] presence_at(input logic fast);
    return fast ? CNT_W'(69) : CNT_W'(550);
  endfunction
  function automatic logic [CNT_W-1:0] reset_last(input logic fast);
    return fast ? CNT_W'(119) : CNT_W'(959);
  endfunction
endpackage

// File: rtl/owm_dq_sync.sv
module owm_dq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/owm_slot_seq.sv
module owm_slot_seq
  import owm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic fast,
  input  logic start_rst,
  input  logic start_slot,
  input  logic slot_bit,
  input  logic dq_s,
  output logic idle,
  output logic oe,
  output logic slot_done,
  output logic rst_done,
  output logic slot_sample,
  output logic pres_sample
);
  sq_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             fast_l;
  logic             bit_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      cnt         <= '0;
      fast_l      <= 1'b0;
      bit_l       <= 1'b0;
      slot_sample <= 1'b0;
      pres_sample <= 1'b1;
    end else if (clr) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (start_rst) begin
            state  <= SQ_RESET;
            fast_l <= fast;
          end else if (start_slot) begin
            state  <= SQ_SLOT;
            fast_l <= fast;
            bit_l  <= slot_bit;
          end
        end
        SQ_RESET: if (tick) begin
          if (cnt == presence_at(fast_l)) pres_sample <= dq_s;
          if (cnt == reset_last(fast_l)) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SQ_SLOT: if (tick) begin
          if (cnt == sample_at(fast_l)) slot_sample <= dq_s;
          if (cnt == slot_last(fast_l)) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (state == SQ_IDLE);
  assign slot_done = !clr && tick && (state == SQ_SLOT)  && (cnt == slot_last(fast_l));
  assign rst_done  = !clr && tick && (state == SQ_RESET) && (cnt == reset_last(fast_l));

  always_comb begin
    case (state)
      SQ_RESET: oe = (cnt < reset_low(fast_l));
      SQ_SLOT:  oe = (cnt < (bit_l ? low_one(fast_l) : low_zero(fast_l)));
      default:  oe = 1'b0;
    endcase
  end

  // R4: the master has let go of the line by the last tick of every slot
  assert_slot_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> !oe);
  // R1: a reset phase never ends while the master still drives low
  assert_reset_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> !oe);
endmodule

// File: rtl/owm_low_watch.sv
module owm_low_watch #(
  parameter int LIMIT = 960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic line_low,
  output logic hit
);
  localparam int LW = $clog2(LIMIT + 1);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr || !line_low)     cnt <= '0;
    else if (tick && cnt != LW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign hit = !clr && line_low && tick && (cnt == LW'(LIMIT));

  // R6: a timeout only fires during a low that was already present a cycle earlier
  assert_hit_on_long_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (line_low && $past(line_low)));
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int SINT_TICKS  = 960,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       data_we,
  input  logic [7:0] data_wdata,
  input  logic       data_re,
  output logic [7:0] data_rdata,
  input  logic       status_re,
  output logic [7:0] status,
  output logic       dq_oe,
  input  logic       dq_in
);
  logic fast_q, direct_q, force_q, soft_q, rst_req;
  logic [BYTE_W-1:0] tx_buf, sh_reg, rx_sh, rx_buf;
  logic tx_full, sh_busy, rx_full;
  logic [IDX_W-1:0] bit_idx;
  logic pres_flag, pres_res, sint_flag;

  logic dq_s, seq_idle, seq_oe, slot_done, rst_done, slot_sample, pres_sample, sint_hit;

  // named events shared by logic and assertions
  logic start_rst, load_evt, start_slot, byte_done, not_busy;
  assign start_rst  = tick && seq_idle && rst_req && !sh_busy && !soft_q;
  assign load_evt   = tick && seq_idle && tx_full && !sh_busy && !rst_req && !soft_q;
  assign start_slot = tick && seq_idle && sh_busy && !soft_q;
  assign byte_done  = slot_done && (bit_idx == IDX_W'(BYTE_W - 1));

  owm_dq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dq_in), .q(dq_s));

  owm_slot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(soft_q), .tick(tick), .fast(fast_q),
    .start_rst(start_rst), .start_slot(start_slot), .slot_bit(sh_reg[0]),
    .dq_s(dq_s), .idle(seq_idle), .oe(seq_oe), .slot_done(slot_done),
    .rst_done(rst_done), .slot_sample(slot_sample), .pres_sample(pres_sample));

  owm_low_watch #(.LIMIT(SINT_TICKS)) u_watch (
    .clk(clk), .rst_n(rst_n), .clr(soft_q), .tick(tick),
    .line_low(!dq_s && !dq_oe), .hit(sint_hit));

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0; direct_q <= 1'b0; force_q <= 1'b0; soft_q <= 1'b0; rst_req <= 1'b0;
    end else begin
      if (ctl_we) begin
        force_q  <= ctl_wdata[CTL_FORCE];
        soft_q   <= ctl_wdata[CTL_SOFT];
        fast_q   <= ctl_wdata[CTL_FAST];
        direct_q <= ctl_wdata[CTL_DIRECT];
      end
      if (soft_q)                            rst_req <= 1'b0;
      else if (ctl_we && ctl_wdata[CTL_RST]) rst_req <= 1'b1;
      else if (start_rst)                    rst_req <= 1'b0;
    end
  end

  // transmit buffer and shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0; tx_full <= 1'b0; sh_reg <= '0; sh_busy <= 1'b0;
      bit_idx <= '0; rx_sh <= '0;
    end else if (soft_q) begin
      tx_full <= 1'b0; sh_busy <= 1'b0; bit_idx <= '0;
    end else begin
      if (data_we) begin
        tx_buf  <= data_wdata;
        tx_full <= 1'b1;
      end else if (load_evt) tx_full <= 1'b0;
      if (load_evt) begin
        sh_reg  <= tx_buf;
        sh_busy <= 1'b1;
        bit_idx <= '0;
      end else if (slot_done) begin
        sh_reg  <= sh_reg >> 1;
        rx_sh   <= {slot_sample, rx_sh[BYTE_W-1:1]};
        bit_idx <= bit_idx + 1'b1;
        if (byte_done) sh_busy <= 1'b0;
      end
    end
  end

  // receive buffer and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0; rx_full <= 1'b0; pres_flag <= 1'b0; pres_res <= 1'b1; sint_flag <= 1'b0;
    end else begin
      if (byte_done) begin
        rx_buf  <= {slot_sample, rx_sh[BYTE_W-1:1]};
        rx_full <= 1'b1;
      end else if (data_re) rx_full <= 1'b0;
      if (rst_done) begin
        pres_flag <= 1'b1;
        pres_res  <= pres_sample;
      end else if (status_re) pres_flag <= 1'b0;
      if (sint_hit)       sint_flag <= 1'b1;
      else if (status_re) sint_flag <= 1'b0;
    end
  end

  assign not_busy   = seq_idle && !sh_busy && !tx_full && !rst_req && dq_s;
  assign dq_oe      = direct_q ? force_q : seq_oe;
  assign data_rdata = rx_buf;
  assign status     = {dq_s, not_busy, sint_flag, rx_full, !sh_busy, !tx_full, pres_res, pres_flag};
  assign ctl_rdata  = {dq_s, 2'b00, direct_q, fast_q, soft_q, force_q, rst_req};

  assert_tx_full_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !soft_q) |=> !status[2]);
  assert_shift_empty_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !load_evt) |=> status[3]);
  assert_rx_cleared_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !byte_done) |=> !status[4]);
  assert_presence_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> status[0]);
  assert_soft_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> (status[2] && status[3] && !seq_oe));
  assert_no_start_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && seq_idle) |=> seq_idle);
endmodule

// File: tb/owm_engine_tb.sv
module owm_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ctl_we = 1'b0, data_we = 1'b0, data_re = 1'b0, status_re = 1'b0;
  logic [7:0] ctl_wdata = '0, data_wdata = '0;
  logic [7:0] ctl_rdata, data_rdata, status;
  logic dq_oe, dq_in = 1'b1;

  owm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re),
    .data_rdata(data_rdata), .status_re(status_re), .status(status), .dq_oe(dq_oe),
    .dq_in(dq_in));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  // bench-side bus and slave model
  bit tick_on = 1'b1, cur_fast = 1'b0, pres_en = 1'b0, resp_en = 1'b0, ext_low = 1'b0;
  bit seen_oe = 1'b0, oe_prev = 1'b0;
  int tdiv = 0, hi_ticks = 0, pull_left = 0, low_ticks = 0;
  logic [7:0] resp_byte = '0;
  logic [2:0] resp_idx = '0;
  logic [15:0] wr_hist = '0;

  always @(negedge clk) begin
    if (tick_on) begin
      tdiv = (tdiv == 3) ? 0 : tdiv + 1;
      tick = (tdiv == 0);
    end else tick = 1'b0;
    if (dq_oe) seen_oe = 1'b1;
    if (dq_oe && !oe_prev) begin
      hi_ticks = 0;
      if (resp_en) begin
        if (!resp_byte[resp_idx]) pull_left = cur_fast ? 4 : 20;
        resp_idx = resp_idx + 3'd1;
      end
    end
    if (dq_oe && tick) hi_ticks++;
    if (!dq_oe && oe_prev) begin
      if (hi_ticks > (cur_fast ? 30 : 300)) begin
        if (pres_en) pull_left = cur_fast ? 15 : 120;
      end else wr_hist = {hi_ticks < (cur_fast ? 4 : 30), wr_hist[15:1]};
    end
    if (tick && pull_left > 0) pull_left--;
    if (tick && ext_low) low_ticks++;
    oe_prev = dq_oe;
    dq_in = !(dq_oe || pull_left > 0 || ext_low);
  end

  function automatic logic [7:0] exp_rx(input logic [7:0] sent, input logic [7:0] resp, input bit en);
    return en ? (sent & resp) : sent;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic data_write(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask
  task automatic data_read();
    @(negedge clk); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
  endtask
  task automatic status_read();
    @(negedge clk); status_re = 1'b1;
    @(negedge clk); status_re = 1'b0;
  endtask
  task automatic wait_idle(input string tag);
    int n = 0;
    @(negedge clk);
    while (!(status[6] && status[2] && status[3] && !ctl_rdata[0]) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(n < 20000, tag, n, 0);
  endtask

  task automatic set_mode(input bit fast);
    cur_fast = fast;
    ctl_write({4'b0, fast, 3'b0});
  endtask

  task automatic byte_op(input bit fast, input logic [7:0] b, input bit rd, input logic [7:0] resp);
    logic [7:0] sent;
    sent = rd ? 8'hFF : b;
    set_mode(fast);
    resp_en = rd; resp_byte = resp; resp_idx = '0; wr_hist = '0;
    data_write(sent);
    chk(status[2] == 1'b0, "R3 buffer not empty after write", status[2], 0);
    repeat (40) @(negedge clk);
    chk(status[6] == 1'b0, "R9 busy during byte", status[6], 0);
    wait_idle("R4 byte completes");
    resp_en = 1'b0;
    chk(wr_hist[15:8] == sent, "R4 slot encoding LSB first", wr_hist[15:8], sent);
    chk(status[4] == 1'b1, "R5 receive full set", status[4], 1);
    chk(data_rdata == exp_rx(sent, resp, rd), rd ? "R2 read byte" : "R2 sampled written byte",
        data_rdata, exp_rx(sent, resp, rd));
    data_read();
    chk(status[4] == 1'b0, "R5 receive full cleared by read", status[4], 0);
  endtask

  task automatic bus_reset(input bit fast, input bit slave);
    set_mode(fast);
    pres_en = slave;
    ctl_write({4'b0, fast, 3'b001});
    chk(ctl_rdata[0] == 1'b1, "R9 reset pending shown", ctl_rdata[0], 1);
    wait_idle("R1 reset completes");
    chk(status[0] == 1'b1, "R1 presence flag set", status[0], 1);
    chk(status[1] == !slave, "R1 presence result", status[1], !slave);
    status_read();
    chk(status[0] == 1'b0, "R1 flag cleared by status read", status[0], 0);
    chk(status[1] == !slave, "R1 result kept after read", status[1], !slave);
    pres_en = 1'b0;
  endtask

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(status == 8'hCE, "R11 status after reset", status, 8'hCE);
    chk(ctl_rdata == 8'h80, "R11 control after reset", ctl_rdata, 8'h80);
    chk(data_rdata == 8'h00, "R11 data after reset", data_rdata, 8'h00);

    bus_reset(1'b0, 1'b1);
    bus_reset(1'b0, 1'b0);
    bus_reset(1'b1, 1'b1);

    byte_op(1'b0, 8'hA5, 1'b0, 8'h00);
    byte_op(1'b0, 8'h00, 1'b1, 8'h3C);
    byte_op(1'b1, 8'h81, 1'b0, 8'h00);
    byte_op(1'b1, 8'h00, 1'b1, 8'hE2);
    for (int i = 0; i < 6; i++) begin
      byte_op(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
    end

    // R3 queueing: second byte written while the first shifts
    set_mode(1'b0);
    wr_hist = '0;
    a = 8'h5A; b = 8'hC3;
    data_write(a);
    while (status[2] == 1'b0) @(negedge clk);
    data_write(b);
    chk(status[2] == 1'b0 && status[3] == 1'b0, "R3 buffer and shift both full", status[3:2], 0);
    wait_idle("R3 queued bytes finish");
    chk(wr_hist == {b, a}, "R3 queued byte order", wr_hist, {b, a});
    chk(data_rdata == b, "R5 receive holds last byte", data_rdata, b);

    // R8 soft reset mid-byte keeps receive data
    wr_hist = '0;
    data_write(8'h0F);
    repeat (200) @(negedge clk);
    ctl_write(8'h04);
    repeat (2) @(negedge clk);
    chk(dq_oe == 1'b0, "R8 line released", dq_oe, 0);
    chk(status[2] && status[3], "R8 transfer emptied", status[3:2], 2'b11);
    chk(status[4] == 1'b1 && data_rdata == b, "R8 receive data kept", data_rdata, b);
    chk(ctl_rdata[2] == 1'b1, "R8 control bits kept", ctl_rdata, 8'h84);
    ctl_write(8'h00);
    data_read();

    // R10 no tick, no bus activity
    tick_on = 1'b0; seen_oe = 1'b0; wr_hist = '0;
    data_write(8'h96);
    repeat (100) @(negedge clk);
    chk(!seen_oe, "R10 line idle without tick", seen_oe, 0);
    chk(status[2] == 1'b0, "R10 byte held in buffer", status[2], 0);
    tick_on = 1'b1;
    wait_idle("R10 resume");
    chk(wr_hist[15:8] == 8'h96, "R10 byte sent after resume", wr_hist[15:8], 8'h96);
    data_read();

    // R7 direct drive
    ctl_write(8'h12);
    repeat (4) @(negedge clk);
    chk(dq_oe == 1'b1, "R7 direct drive low", dq_oe, 1);
    chk(status[7] == 1'b0 && ctl_rdata[7] == 1'b0, "R7 line level shown", status[7], 0);
    ctl_write(8'h90);
    repeat (4) @(negedge clk);
    chk(dq_oe == 1'b0, "R7 direct release", dq_oe, 0);
    chk(ctl_rdata == 8'h90, "R7 read-only level bit", ctl_rdata, 8'h90);
    ctl_write(8'h00);

    // R6 slave-low timeout
    status_read();
    low_ticks = 0; ext_low = 1'b1;
    while (low_ticks < 900) @(negedge clk);
    chk(status[6] == 1'b0, "R9 busy while line low", status[6], 0);
    ext_low = 1'b0;
    repeat (8) @(negedge clk);
    chk(status[5] == 1'b0, "R6 no flag at 900 ticks", status[5], 0);
    low_ticks = 0; ext_low = 1'b1;
    while (low_ticks < 1000) @(negedge clk);
    ext_low = 1'b0;
    repeat (8) @(negedge clk);
    chk(status[5] == 1'b1, "R6 flag after long low", status[5], 1);
    status_read();
    chk(status[5] == 1'b0, "R6 flag cleared by status read", status[5], 0);
    chk(status[6] == 1'b1, "R9 not busy when idle", status[6], 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule